// File: doc/BRIEF.md
# SCSI Controller Status and FIFO Logic

This block is the register-side status machinery of a SCSI bus controller. A host reaches it through a byte-wide register port with a 6-bit address. Reads and writes go to two separate banks, so a write never changes what a read of the same address returns. The read bank holds four registers: status, interrupt cause, sequence step and FIFO flags. It also holds a chip identification byte and a FIFO data port that drains a 32-byte linear transfer buffer. The host fills that buffer through the same address in the write bank.

A sequencer, which lies outside this block, reports finished bus operations as single-cycle strobes. There are five of them: selection, command done, status phase, DMA done and bus reset. Each strobe loads its own values into the read registers. Most strobes also request an interrupt. The interrupt request is a level signal held by a two-state machine with the states IRQ_IDLE and IRQ_ACTIVE. The transition *raise* goes from IRQ_IDLE to IRQ_ACTIVE. It is caused by an event strobe or by a read that pops a byte. The transition *ack* goes from IRQ_ACTIVE to IRQ_IDLE. It is caused by a read of the interrupt-cause register, unless a raise happens in the same cycle, because a raise takes precedence. The state machine stays where it is in every other case.

The block also computes the command-phase transfer length from the programmed DMA length.

Top module: `scsi_status_fifo`

## Requirements
- R1: After reset, the status (addr 4), interrupt (addr 5), sequence (addr 6) and flags (addr 7) registers read 0x00. Address 0x0E reads the identification value 0x04. `irq_o` is low.
- R2: Writes and reads use separate banks. Writing 0x05 to address 4 leaves a read of address 4 unchanged.
- R3: Writing address 2 appends a byte at the write pointer. Reading address 2 returns the byte at the read pointer, advances that pointer and raises `irq_o`. Bytes come out in the order they went in.
- R4: Reading address 2 while the buffer is empty returns 0x00. It moves no pointer and does not raise `irq_o`.
- R5: The buffer is linear, not circular. A write is accepted only while the write pointer is below 32, so writes into a full buffer are dropped. When a read takes the last stored byte, both pointers return to 0. After that, a full 32 bytes fit again.
- R6: Reading address 5 returns the interrupt cause without clearing it. It also clears status bits 7, 6 and 5 (interrupt, gross error, parity error) and drops `irq_o` on the next edge.
- R7: A bus-reset strobe loads 0x80 (reset bit 7) into the interrupt register. It raises `irq_o` only when bit 6 of write register 8 is 0.
- R8: A selection strobe whose target (bits [2:0] of write register 4) has a low `dev_present` bit loads status 0x80, interrupt 0x20 (disconnect, bit 5) and sequence 0, then raises `irq_o`.
- R9: A command-done strobe loads status 0x90 plus a phase in bits [2:0]. The phase is 1 for data-in and 0 for data-out. The strobe also loads interrupt 0x18 (bus service bit 4 plus function complete bit 3) and sequence 4, then raises `irq_o`.
- R10: A status-phase strobe loads status 0x93, interrupt 0x18 and sequence 4, then raises `irq_o`. When `ev_use_dma` is 0, it also puts `ev_sense` and then 0x00 into the buffer and sets flags to 2. When `ev_use_dma` is 1, the buffer and the flags register stay as they were.
- R11: A DMA-done strobe sets status bits 7 and 4, loads interrupt 0x10, clears sequence and flags, and raises `irq_o`.
- R12: `cmd_len` equals the 16-bit length in write registers 1 (high byte) and 0 (low byte), capped at 32.
- R13: A selection strobe whose target is present changes no register and does not raise `irq_o`.
- R14: Once `irq_o` is high, it stays high until address 5 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd` |
| ev_select | input | 1 | Selection attempt finished |
| ev_cmd_done | input | 1 | Command phase finished |
| ev_status | input | 1 | Status phase reached |
| ev_dma_done | input | 1 | DMA transfer finished |
| ev_bus_reset | input | 1 | Bus reset issued |
| ev_dir_in | input | 1 | Data direction for command done (1 = in) |
| ev_use_dma | input | 1 | Status phase goes through DMA |
| ev_sense | input | 8 | Sense byte for the status phase |
| dev_present | input | 8 | One bit per target, 1 = device exists |
| cmd_len | output | 6 | Command-phase transfer length |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is the pointer rewind. Whether both pointers go back to zero can only be seen through how many bytes the buffer accepts afterwards. The stimulus first pushes and drains a short run of three bytes, which leaves the write pointer away from zero unless it is rewound. It then writes 32 bytes and one extra byte, and reads all of them back. If the rewind were missing, the last bytes would be dropped and the read-back would come up short. The masked bus reset is the second hard case, and it needs write register 8 set before the strobe arrives.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam logic [7:0] ST_INT   = 8'h80;
    localparam logic [7:0] ST_GERR  = 8'h40;
    localparam logic [7:0] ST_PERR  = 8'h20;
    localparam logic [7:0] ST_TC    = 8'h10;
    localparam logic [2:0] PH_OUT   = 3'd0;
    localparam logic [2:0] PH_IN    = 3'd1;
    localparam logic [2:0] PH_STAT  = 3'd3;

    localparam logic [7:0] IC_RESET = 8'h80;
    localparam logic [7:0] IC_DISC  = 8'h20;
    localparam logic [7:0] IC_SVC   = 8'h10;
    localparam logic [7:0] IC_DONE  = 8'h08;

    localparam logic [7:0] SQ_IDLE  = 8'h00;
    localparam logic [7:0] SQ_CMD   = 8'h04;
    localparam logic [7:0] CHIP_ID  = 8'h04;

    localparam int A_LEN_LO = 0;
    localparam int A_LEN_HI = 1;
    localparam int A_FIFO   = 2;
    localparam int A_STAT   = 4;
    localparam int A_ICAUSE = 5;
    localparam int A_SEQ    = 6;
    localparam int A_FLAGS  = 7;
    localparam int A_CFG    = 8;
    localparam int A_ID     = 14;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/sfs_xfer_buf.sv
module sfs_xfer_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop,
    input  logic                        load_pair,
    input  logic [DW-1:0]               load_data,
    output logic [DW-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rptr;
    logic [PW-1:0] wptr;
    logic          nonempty;

    assign count    = wptr - rptr;
    assign nonempty = (wptr != rptr);
    assign head     = nonempty ? mem[rptr[IW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wptr <= '0;
        end else if (load_pair) begin
            rptr <= '0;
            wptr <= PW'(2);
        end else if (push && (wptr < PW'(DEPTH))) begin
            wptr <= wptr + 1'b1;
        end else if (pop && nonempty) begin
            if (PW'(rptr + 1'b1) == wptr) begin
                rptr <= '0;
                wptr <= '0;
            end else begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load_pair) begin
            mem[0] <= load_data;
            mem[1] <= '0;
        end else if (push && (wptr < PW'(DEPTH))) begin
            mem[wptr[IW-1:0]] <= push_data;
        end
    end
endmodule

// File: rtl/sfs_irq_ctrl.sv
module sfs_irq_ctrl
    import sfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE:   if (raise) state_nx = IRQ_ACTIVE;
            IRQ_ACTIVE: if (ack && !raise) state_nx = IRQ_IDLE;
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        irq = (state == IRQ_ACTIVE);
    end
endmodule

// File: rtl/scsi_status_fifo.sv
module scsi_status_fifo
    import sfs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DEPTH = 32,
    parameter int NTGT  = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(NTGT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            ev_select,
    input  logic            ev_cmd_done,
    input  logic            ev_status,
    input  logic            ev_dma_done,
    input  logic            ev_bus_reset,
    input  logic            ev_dir_in,
    input  logic            ev_use_dma,
    input  logic [7:0]      ev_sense,
    input  logic [NTGT-1:0] dev_present,
    output logic [LW-1:0]   cmd_len,
    output logic            irq_o
);
    logic [7:0]    st_q, ic_q, sq_q, fl_q;
    logic [7:0]    len_lo_q, len_hi_q;
    logic [TW-1:0] tgt_id;
    logic          rst_mask;

    logic          rd_fifo, wr_fifo, rd_icause;
    logic          sel_fail;
    logic          any_ev;
    logic          raise;
    logic [7:0]    buf_head;
    logic [LW-1:0] buf_cnt;
    logic [15:0]   len16;

    assign rd_fifo   = reg_rd && (reg_addr == AW'(A_FIFO));
    assign wr_fifo   = reg_wr && (reg_addr == AW'(A_FIFO));
    assign rd_icause = reg_rd && (reg_addr == AW'(A_ICAUSE));
    assign sel_fail  = ev_select && !dev_present[tgt_id];
    assign any_ev    = ev_select | ev_cmd_done | ev_status | ev_dma_done | ev_bus_reset;

    assign raise = sel_fail | ev_cmd_done | ev_status | ev_dma_done
                 | (ev_bus_reset && !rst_mask)
                 | (rd_fifo && (buf_cnt != '0));

    // write bank: only the fields the block decodes are stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_lo_q <= '0;
            len_hi_q <= '0;
            tgt_id   <= '0;
            rst_mask <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(A_LEN_LO)) len_lo_q <= reg_wdata;
            if (reg_addr == AW'(A_LEN_HI)) len_hi_q <= reg_wdata;
            if (reg_addr == AW'(A_STAT))   tgt_id   <= reg_wdata[TW-1:0];
            if (reg_addr == AW'(A_CFG))    rst_mask <= reg_wdata[6];
        end
    end

    // read bank: loaded by events, acknowledged by reading the cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            ic_q <= '0;
            sq_q <= '0;
            fl_q <= '0;
        end else if (any_ev) begin
            if (sel_fail) begin
                st_q <= ST_INT | {5'b0, PH_OUT};
                ic_q <= IC_DISC;
                sq_q <= SQ_IDLE;
            end else if (ev_cmd_done) begin
                st_q <= ST_INT | ST_TC | {5'b0, (ev_dir_in ? PH_IN : PH_OUT)};
                ic_q <= IC_SVC | IC_DONE;
                sq_q <= SQ_CMD;
            end else if (ev_status) begin
                st_q <= ST_INT | ST_TC | {5'b0, PH_STAT};
                ic_q <= IC_SVC | IC_DONE;
                sq_q <= SQ_CMD;
                if (!ev_use_dma) fl_q <= 8'd2;
            end else if (ev_dma_done) begin
                st_q <= st_q | ST_INT | ST_TC;
                ic_q <= IC_SVC;
                sq_q <= SQ_IDLE;
                fl_q <= '0;
            end else if (ev_bus_reset) begin
                ic_q <= IC_RESET;
            end
        end else if (rd_icause) begin
            st_q <= st_q & ~(ST_INT | ST_GERR | ST_PERR);
        end
    end

    sfs_xfer_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_fifo && !any_ev),
        .push_data (reg_wdata),
        .pop       (rd_fifo && !any_ev),
        .load_pair (ev_status && !ev_use_dma && !ev_select && !ev_cmd_done),
        .load_data (ev_sense),
        .head      (buf_head),
        .count     (buf_cnt)
    );

    sfs_irq_ctrl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .ack   (rd_icause),
        .irq   (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_FIFO))        reg_rdata = buf_head;
        else if (reg_addr == AW'(A_STAT))   reg_rdata = st_q;
        else if (reg_addr == AW'(A_ICAUSE)) reg_rdata = ic_q;
        else if (reg_addr == AW'(A_SEQ))    reg_rdata = sq_q;
        else if (reg_addr == AW'(A_FLAGS))  reg_rdata = fl_q;
        else if (reg_addr == AW'(A_ID))     reg_rdata = CHIP_ID;
    end

    assign len16   = {len_hi_q, len_lo_q};
    assign cmd_len = (len16 < 16'(DEPTH)) ? len16[LW-1:0] : LW'(DEPTH);
endmodule

// File: rtl/sfs_status_chk.sv
module sfs_status_chk #(
    parameter int AW    = 6,
    parameter int DEPTH = 32,
    parameter int NTGT  = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(NTGT)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_rd,
    input logic [AW-1:0]   reg_addr,
    input logic [7:0]      reg_rdata,
    input logic            ev_select,
    input logic            ev_cmd_done,
    input logic            ev_status,
    input logic            ev_dma_done,
    input logic            ev_bus_reset,
    input logic [NTGT-1:0] dev_present,
    input logic [LW-1:0]   cmd_len,
    input logic            irq_o,
    input logic [TW-1:0]   tgt_id,
    input logic            rst_mask,
    input logic [LW-1:0]   buf_cnt
);
    logic ev_any;
    assign ev_any = ev_select | ev_cmd_done | ev_status | ev_dma_done | ev_bus_reset;

    a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AW'(5) && !ev_any) |=> !irq_o);

    a_r14_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(reg_rd && reg_addr == AW'(5))) |=> irq_o);

    a_r7_masked_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bus_reset && rst_mask && !irq_o && !reg_rd
         && !ev_select && !ev_cmd_done && !ev_status && !ev_dma_done) |=> !irq_o);

    a_r8_select_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_select && !dev_present[tgt_id]) |=> irq_o);

    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AW'(2) && buf_cnt == '0) |-> reg_rdata == 8'h00);

    a_r1_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AW'(14)) |-> reg_rdata == 8'h04);

    a_r12_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= LW'(DEPTH));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= LW'(DEPTH));
endmodule

bind scsi_status_fifo sfs_status_chk #(.AW(AW), .DEPTH(DEPTH), .NTGT(NTGT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .ev_select    (ev_select),
    .ev_cmd_done  (ev_cmd_done),
    .ev_status    (ev_status),
    .ev_dma_done  (ev_dma_done),
    .ev_bus_reset (ev_bus_reset),
    .dev_present  (dev_present),
    .cmd_len      (cmd_len),
    .irq_o        (irq_o),
    .tgt_id       (tgt_id),
    .rst_mask     (rst_mask),
    .buf_cnt      (buf_cnt)
);

// File: tb/scsi_status_fifo_tb.sv
module scsi_status_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_select = 0, ev_cmd_done = 0, ev_status = 0, ev_dma_done = 0, ev_bus_reset = 0;
    logic       ev_dir_in = 0, ev_use_dma = 0;
    logic [7:0] ev_sense = '0;
    logic [7:0] dev_present = 8'h01;
    logic [5:0] cmd_len;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t      sb_q[$];
    logic [7:0] obs;
    event       mon_ev;

    always #4 clk = ~clk;

    scsi_status_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_select(ev_select), .ev_cmd_done(ev_cmd_done), .ev_status(ev_status),
        .ev_dma_done(ev_dma_done), .ev_bus_reset(ev_bus_reset),
        .ev_dir_in(ev_dir_in), .ev_use_dma(ev_use_dma), .ev_sense(ev_sense),
        .dev_present(dev_present), .cmd_len(cmd_len), .irq_o(irq_o)
    );

    // monitor: pops the expected item and compares with the observed read data
    initial begin
        forever begin
            @(mon_ev);
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL monitor: unexpected read value %02h", obs);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (obs !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        reg_rd = 0; reg_wr = 0;
        ev_select = 0; ev_cmd_done = 0; ev_status = 0; ev_dma_done = 0; ev_bus_reset = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #1;
        obs = reg_rdata;
        -> mon_ev;
        finish_cycle();
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        finish_cycle();
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, e);
        end
    endtask

    task automatic ev(input int which);
        @(negedge clk);
        case (which)
            0: ev_select = 1;
            1: ev_cmd_done = 1;
            2: ev_status = 1;
            3: ev_dma_done = 1;
            default: ev_bus_reset = 1;
        endcase
        finish_cycle();
    endtask

    task automatic report();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk({7'b0, irq_o}, 8'h00, "R1 irq");
        rd(6'd4, 8'h00, "R1 status");
        rd(6'd5, 8'h00, "R1 icause");
        rd(6'd6, 8'h00, "R1 seq");
        rd(6'd7, 8'h00, "R1 flags");
        rd(6'd14, 8'h04, "R1 chip id");
        // R2 separate banks
        wr(6'd4, 8'h05);
        rd(6'd4, 8'h00, "R2 bank split");
        // R8 selection failure on target 5
        ev(0);
        chk({7'b0, irq_o}, 8'h01, "R8 irq");
        rd(6'd4, 8'h80, "R8 status");
        rd(6'd6, 8'h00, "R8 seq");
        chk({7'b0, irq_o}, 8'h01, "R14 irq held");
        rd(6'd5, 8'h20, "R8 icause");
        chk({7'b0, irq_o}, 8'h00, "R6 irq dropped");
        rd(6'd4, 8'h00, "R6 status cleared");
        // R13 selection of a present target
        wr(6'd4, 8'h00);
        ev(0);
        chk({7'b0, irq_o}, 8'h00, "R13 irq");
        rd(6'd4, 8'h00, "R13 status");
        rd(6'd5, 8'h20, "R13 icause");
        // R9 command done, in then out
        ev_dir_in = 1;
        ev(1);
        chk({7'b0, irq_o}, 8'h01, "R9 irq");
        rd(6'd4, 8'h91, "R9 status in");
        rd(6'd6, 8'h04, "R9 seq");
        rd(6'd5, 8'h18, "R9 icause");
        rd(6'd4, 8'h11, "R6 only top bits cleared");
        ev_dir_in = 0;
        ev(1);
        rd(6'd4, 8'h90, "R9 status out");
        rd(6'd5, 8'h18, "R9 icause out");
        // R10 status phase without DMA
        ev_sense = 8'hA5; ev_use_dma = 0;
        ev(2);
        rd(6'd7, 8'h02, "R10 flags");
        rd(6'd4, 8'h93, "R10 status");
        rd(6'd5, 8'h18, "R10 icause");
        rd(6'd2, 8'hA5, "R10 sense byte");
        chk({7'b0, irq_o}, 8'h01, "R3 pop raises irq");
        rd(6'd2, 8'h00, "R10 second byte");
        rd(6'd5, 8'h18, "R3 ack");
        rd(6'd2, 8'h00, "R4 empty read");
        chk({7'b0, irq_o}, 8'h00, "R4 no irq on empty");
        // R10 status phase with DMA
        wr(6'd2, 8'h5C);
        ev_use_dma = 1; ev_sense = 8'h77;
        ev(2);
        rd(6'd2, 8'h5C, "R10 dma leaves buffer");
        rd(6'd7, 8'h02, "R10 dma leaves flags");
        rd(6'd5, 8'h18, "R10 dma icause");
        // R11 DMA done
        ev(3);
        chk({7'b0, irq_o}, 8'h01, "R11 irq");
        rd(6'd6, 8'h00, "R11 seq");
        rd(6'd7, 8'h00, "R11 flags");
        rd(6'd4, 8'h93, "R11 status");
        rd(6'd5, 8'h10, "R11 icause");
        // R7 bus reset, unmasked then masked
        wr(6'd8, 8'h00);
        ev(4);
        chk({7'b0, irq_o}, 8'h01, "R7 irq unmasked");
        rd(6'd5, 8'h80, "R7 icause");
        wr(6'd8, 8'h40);
        ev(4);
        chk({7'b0, irq_o}, 8'h00, "R7 irq masked");
        rd(6'd5, 8'h80, "R7 icause masked");
        // R3 and R5: short run, then a full buffer plus an overflow write
        wr(6'd2, 8'h11); wr(6'd2, 8'h22); wr(6'd2, 8'h33);
        rd(6'd2, 8'h11, "R3 order 0");
        rd(6'd2, 8'h22, "R3 order 1");
        rd(6'd2, 8'h33, "R3 order 2");
        for (int i = 0; i < 32; i++) wr(6'd2, 8'(i * 3 + 1));
        wr(6'd2, 8'hEE);
        for (int i = 0; i < 32; i++) rd(6'd2, 8'(i * 3 + 1), "R5 rewind refill");
        rd(6'd2, 8'h00, "R5 overflow dropped");
        rd(6'd5, 8'h80, "R5 ack");
        // R12 command length cap
        wr(6'd1, 8'h00); wr(6'd0, 8'h10); #1 chk({2'b0, cmd_len}, 8'd16, "R12 len 16");
        wr(6'd0, 8'h20); #1 chk({2'b0, cmd_len}, 8'd32, "R12 len 32");
        wr(6'd0, 8'h21); #1 chk({2'b0, cmd_len}, 8'd32, "R12 len 33 capped");
        wr(6'd1, 8'h01); wr(6'd0, 8'h00); #1 chk({2'b0, cmd_len}, 8'd32, "R12 len 256 capped");
        wr(6'd1, 8'h00); wr(6'd0, 8'h05); #1 chk({2'b0, cmd_len}, 8'd5, "R12 len 5");
        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        report();
    end
endmodule